// File: doc/BRIEF.md
# Serial Addressed Register Loader

This block lets a host controller configure sixteen 8-bit control registers over two wires: a serial clock and a serial data line. Both lines are sampled by a fast system clock. They pass through synchronizers, and their edges are found in that clock domain. On every rising edge of the serial clock, one bit of the data line is taken into a shift register. A frame is twelve bits long. The eight payload bits come first, least significant first. The four address bits come last, also least significant first.

The data line also acts as the commit signal. When the data line rises while the serial clock is high, and exactly twelve bits have been collected, the payload is written to the addressed register. The block raises a write strobe for one system cycle and shows the address and payload beside it. If the data line rises while the clock is high at any other bit count, the frame is thrown away. In every case the bit counter goes back to zero, so the next frame can start at once. The sixteen register values are always visible on one flat output bus.

Top module: `serreg_loader`

## Requirements
- R1: After reset, all sixteen registers read zero and the write strobe is low.
- R2: A bit is taken from the data line only on a rising edge of the serial clock. Bits 0..7 of a frame are the payload, LSB first. Bits 8..11 are the address, LSB first. Register k occupies `reg_flat_o[8k+7:8k]`.
- R3: A commit happens only when the data line rises while the serial clock is high and exactly 12 bits have been collected. The strobe then carries the frame's address and payload, and the addressed register holds the payload one system cycle after the strobe.
- R4: A data rise while the clock is high after fewer than 12 bits gives no strobe and changes no register. A full frame sent after it commits normally.
- R5: A data rise while the clock is high after more than 12 bits gives no strobe and changes no register. The bit count saturates at 13.
- R6: Data changes while the serial clock is low have no effect, rising edges included. A data fall while the clock is high has no effect.
- R7: After any commit or discard the bit counter is zero, so frames can be sent back to back.
- R8: The strobe is high for exactly one system cycle per committed frame. Registers other than the addressed one keep their values.
- R9: Both serial lines pass through a two-stage synchronizer. Correct operation requires serial high and low phases of at least 10 system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from host |
| ser_dat_i | input | 1 | Serial data and commit line from host |
| wr_stb_o | output | 1 | One-cycle commit strobe |
| wr_addr_o | output | 4 | Address of committed frame |
| wr_data_o | output | 8 | Payload of committed frame |
| reg_flat_o | output | 128 | All sixteen registers, register k at bits 8k+7:8k |

## Verification
The assertions assume the host keeps data steady across each serial clock rise. They also assume the high and low phases are long enough to survive the synchronizer, so clock and data edges never land in the same system cycle. The bench meets this by spacing each serial phase twelve system cycles apart. It changes data only while the clock is low, or, for the commit sequence, a few cycles into a high phase. Random frames vary the address, the payload and the bit count (short, exact and long). Some frames also add data glitches during low phases.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int unsigned DFLT_DATA_W = 8;
  localparam int unsigned DFLT_ADDR_W = 4;
  localparam int unsigned DFLT_SYNC_N = 2;

  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_SHIFT = 2'd1,
    EV_XFER  = 2'd2
  } ser_event_e;
endpackage

// File: rtl/serreg_rst_sync.sv
module serreg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/serreg_edge.sv
module serreg_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= 1'b0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/serreg_shifter.sv
module serreg_shifter
  import serreg_pkg::*;
#(
  parameter int unsigned DATA_W = DFLT_DATA_W,
  parameter int unsigned ADDR_W = DFLT_ADDR_W,
  localparam int unsigned WORD_W = DATA_W + ADDR_W,
  localparam int unsigned CNT_MAX = WORD_W + 1,
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_lvl,
  input  logic              sdat_rise,
  input  logic              sdat_lvl,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  ser_event_e        ev;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              sr_en;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              stb_q, stb_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    if (sdat_rise && sclk_lvl) ev = EV_XFER;
    else if (sclk_rise)        ev = EV_SHIFT;
    else                       ev = EV_IDLE;
  end

  always_comb begin
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    sr_en  = 1'b0;
    stb_d  = 1'b0;
    addr_d = addr_q;
    data_d = data_q;
    unique case (ev)
      EV_XFER: begin
        cnt_d = '0;
        if (cnt_q == CNT_W'(WORD_W)) begin
          stb_d  = 1'b1;
          addr_d = sr_q[WORD_W-1 -: ADDR_W];
          data_d = sr_q[DATA_W-1:0];
        end
      end
      EV_SHIFT: begin
        sr_en = 1'b1;
        sr_d  = {sdat_lvl, sr_q[WORD_W-1:1]};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (stb_d) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_stb_o  = stb_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned NREG = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] reg_flat_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    logic              we;

    assign we = wr_stb && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (we) val_q <= wr_data;
    end

    assign reg_flat_o[g*DATA_W +: DATA_W] = val_q;
  end
endmodule

// File: rtl/serreg_loader.sv
module serreg_loader
  import serreg_pkg::*;
#(
  parameter int unsigned DATA_W = DFLT_DATA_W,
  parameter int unsigned ADDR_W = DFLT_ADDR_W,
  parameter int unsigned SYNC_N = DFLT_SYNC_N,
  localparam int unsigned NREG = 1 << ADDR_W,
  localparam int unsigned CNT_W = $clog2(DATA_W + ADDR_W + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk_i,
  input  logic                   ser_dat_i,
  output logic                   wr_stb_o,
  output logic [ADDR_W-1:0]      wr_addr_o,
  output logic [DATA_W-1:0]      wr_data_o,
  output logic [NREG*DATA_W-1:0] reg_flat_o
);
  logic             rst_i_n;
  logic             sclk_lvl, sclk_rise;
  logic             sdat_lvl, sdat_rise;
  logic [CNT_W-1:0] bit_cnt;

  serreg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  serreg_edge #(.STAGES(SYNC_N)) u_clk_edge (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .din    (ser_clk_i),
    .lvl_o  (sclk_lvl),
    .rise_o (sclk_rise)
  );

  serreg_edge #(.STAGES(SYNC_N)) u_dat_edge (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .din    (ser_dat_i),
    .lvl_o  (sdat_lvl),
    .rise_o (sdat_rise)
  );

  serreg_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .sclk_rise (sclk_rise),
    .sclk_lvl  (sclk_lvl),
    .sdat_rise (sdat_rise),
    .sdat_lvl  (sdat_lvl),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .bit_cnt_o (bit_cnt)
  );

  serreg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_stb     (wr_stb_o),
    .wr_addr    (wr_addr_o),
    .wr_data    (wr_data_o),
    .reg_flat_o (reg_flat_o)
  );
endmodule

// File: rtl/serreg_loader_chk.sv
module serreg_loader_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned WORD_W = DATA_W + ADDR_W,
  localparam int unsigned NREG = 1 << ADDR_W,
  localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_stb,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [DATA_W-1:0]      wr_data,
  input logic [NREG*DATA_W-1:0] reg_flat,
  input logic [CNT_W-1:0]       bit_cnt
);
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
    end else if (wr_stb) begin
      cap_addr <= wr_addr;
      cap_data <= wr_data;
    end
  end

  // R3: a strobe follows a cycle in which exactly a full frame was held
  assert_commit_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(bit_cnt) == CNT_W'(WORD_W)));

  // R2: the strobed payload lands in the strobed register
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (reg_flat[cap_addr*DATA_W +: DATA_W] == cap_data));

  // R8: strobe lasts one cycle
  assert_stb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R8: no strobe, no register change
  assert_bank_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(reg_flat));

  // R7: counter is clear whenever a commit is issued
  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (bit_cnt == '0));

  // R5: count saturates one past a full frame
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W + 1));
endmodule

bind serreg_loader serreg_loader_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_stb   (wr_stb_o),
  .wr_addr  (wr_addr_o),
  .wr_data  (wr_data_o),
  .reg_flat (reg_flat_o),
  .bit_cnt  (bit_cnt)
);

// File: tb/sim_serreg_loader.sv
`timescale 1ns/1ps
module sim_serreg_loader;
  localparam int HALF = 12;

  logic         clk;
  logic         rst_n;
  logic         ser_clk, ser_dat;
  logic         wr_stb;
  logic [3:0]   wr_addr;
  logic [7:0]   wr_data;
  logic [127:0] reg_flat;

  logic [7:0] exp_reg [16];
  int         n_checks, n_fail;
  int         stb_cnt;
  logic [3:0] cap_addr;
  logic [7:0] cap_data;
  bit         done;

  serreg_loader u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk_i  (ser_clk),
    .ser_dat_i  (ser_dat),
    .wr_stb_o   (wr_stb),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .reg_flat_o (reg_flat)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_cnt  <= 0;
      cap_addr <= '0;
      cap_data <= '0;
    end else if (wr_stb) begin
      stb_cnt  <= stb_cnt + 1;
      cap_addr <= wr_addr;
      cap_data <= wr_data;
    end
  end

  function automatic bit commits(input int nbits);
    return nbits == 12;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    bit ok = 1'b1;
    n_checks++;
    for (int i = 0; i < 16; i++) begin
      if (reg_flat[i*8 +: 8] !== exp_reg[i]) begin
        if (ok) n_fail++;
        ok = 1'b0;
        $display("FAIL %s reg%0d actual=%02h expected=%02h", req, i, reg_flat[i*8 +: 8], exp_reg[i]);
      end
    end
  endtask

  // clock left high on return
  task automatic send_bit(input bit b, input bit noisy);
    ser_clk = 1'b0;
    wait_cyc(2);
    if (noisy) begin
      ser_dat = 1'b0; wait_cyc(3);
      ser_dat = 1'b1; wait_cyc(3);
    end
    ser_dat = b;
    wait_cyc(HALF - 2 - (noisy ? 6 : 0));
    ser_clk = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic commit_seq;
    ser_dat = 1'b0; wait_cyc(4);
    ser_dat = 1'b1; wait_cyc(4);
    ser_clk = 1'b0; wait_cyc(HALF);
  endtask

  task automatic send_frame(input logic [3:0] a, input logic [7:0] d,
                            input int nbits, input bit noisy, input string req);
    logic [11:0] w;
    int          s0;
    w  = {a, d};
    s0 = stb_cnt;
    for (int i = 0; i < nbits; i++)
      send_bit((i < 12) ? w[i] : 1'($urandom % 2), noisy);
    commit_seq();
    wait_cyc(4);
    if (commits(nbits)) begin
      exp_reg[a] = d;
      check_int({req, " strobe count"}, stb_cnt - s0, 1);
      check_int({req, " strobe addr"}, int'(cap_addr), int'(a));
      check_int({req, " strobe data"}, int'(cap_data), int'(d));
    end else begin
      check_int({req, " no strobe"}, stb_cnt - s0, 0);
    end
    check_bank(req);
  endtask

  initial begin
    done = 1'b0;
    n_checks = 0;
    n_fail = 0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed_2025));
    for (int i = 0; i < 16; i++) exp_reg[i] = 8'h00;
    rst_n   = 1'b0;
    ser_clk = 1'b0;
    ser_dat = 1'b1;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(6);

    // R1 reset state
    check_bank("R1 reset bank");
    check_int("R1 reset strobe", int'(wr_stb), 0);

    // R2 R3 directed frames, bit order
    send_frame(4'h1, 8'hA5, 12, 1'b0, "R2 frame a1");
    send_frame(4'hF, 8'h01, 12, 1'b0, "R3 frame top");
    send_frame(4'h8, 8'h80, 12, 1'b0, "R2 msb/addr3");
    // R4 short, then a full frame
    send_frame(4'h2, 8'h3C, 7, 1'b0, "R4 short");
    send_frame(4'h2, 8'h3C, 12, 1'b0, "R4 after short");
    send_frame(4'h4, 8'hFF, 1, 1'b0, "R4 one bit");
    // R5 long frames
    send_frame(4'h3, 8'h77, 13, 1'b0, "R5 thirteen");
    send_frame(4'h3, 8'h66, 20, 1'b0, "R5 twenty");
    // R6 glitches while clock low
    send_frame(4'h5, 8'h5A, 12, 1'b1, "R6 noisy");
    send_frame(4'h6, 8'h00, 12, 1'b1, "R6 noisy zero");
    // R7 back to back, R8 others preserved
    send_frame(4'h1, 8'h11, 12, 1'b0, "R7 overwrite");
    send_frame(4'h0, 8'hC3, 12, 1'b0, "R8 reg0");

    // random mix
    for (int k = 0; k < 50; k++) begin
      int sel = $urandom % 8;
      int nb  = (sel == 0) ? 1 + ($urandom % 11) : (sel == 1) ? 13 + ($urandom % 4) : 12;
      send_frame(4'($urandom), 8'($urandom), nb, 1'($urandom % 2), "R9 random");
    end

    report();
  end
endmodule